// File: doc/BRIEF.md
# Tree Sum Reducer

The block folds a set of partial sums, held in an internal array of slots, into one total. Software or an upstream engine first writes the values into the slots through a load port while the unit is idle. A start pulse then hands over the number of valid slots. The unit runs a sequence of halving rounds. In each round, the lower part of the active slots adds in the matching upper part. When the active count is odd, slot 0 also takes in the element that would otherwise be left without a partner.

Each round completes on a single clock edge, and all additions in it use the values from before that round. This makes the register boundary between rounds the synchronization point: no round can see a half-finished result of the previous one. When the active count reaches one, the total sits in slot 0 and a one-cycle done pulse marks it valid. Arithmetic is two's-complement and wraps modulo 2^WIDTH.

Top module: `tree_sum_reducer`

## Requirements
- R1: After reset, done is low, the unit is idle, and every slot, and therefore total, reads zero.
- R2: While idle, a cycle with loadEn high writes loadData into slot loadIdx. Apart from a load into slot 0, total does not change while the unit is idle.
- R3: For any count from 2 to MAX_N, total equals the sum of slots 0 to count-1 at the cycle done is high. Slots at or above count take no part in it.
- R4: When the active count of a round is odd, slot 0 adds in slot count-1 in that same round. An element placed only in the last slot of an odd count therefore reaches the total.
- R5: For a count of 2 or more, done is high right after the (floor(log2(count))+1)-th rising edge. The edge that samples start is the first of these.
- R6: done is high for exactly one cycle per reduction.
- R7: A count of 0 or 1 runs no round. done rises right after the edge that samples start, and total is the unchanged slot 0.
- R8: start and loadEn are ignored while a reduction is running. A second start gives neither a second done nor a changed total, and a load gives no changed total.
- R9: Additions wrap modulo 2^WIDTH with no saturation.
- R10: A count above MAX_N is treated as MAX_N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a reduction; sampled only when idle |
| sumCount | input | HW | Number of valid slots, latched with start |
| loadEn | input | 1 | Write strobe for the slot array (idle only) |
| loadIdx | input | IW | Slot index for a write |
| loadData | input | WIDTH | Value written into the slot |
| done | output | 1 | One-cycle pulse: total is final |
| total | output | WIDTH | Current content of slot 0 |

## Verification
The reduction runs on counts of 0, 1, 2, 3, 5, 7, 100, 127 and the full 128, plus one count above the maximum. This covers even and odd sequences, such as 100, which passes through 25 and 3, and it shows whether the odd-count fold fires in the right round. The data patterns each expose a different class of fault:
- All ones shows that the number of terms is correct.
- Index-weighted values and a hashed pattern catch a wrong partner index.
- A single nonzero value in the last valid slot catches a missing fold.
- Near-full-scale values check that the sum wraps.

Nonzero values are loaded above the count in every case, so a round that reaches past the active range shows up as a wrong total. The latency of each run is compared with the expected round count. One run receives a second start and a stray load partway through.

// File: rtl/tree_sum_pkg.sv
package tree_sum_pkg;

  // Strobes handed from the sequencer to the slot array.
  typedef struct packed {
    logic slotWrite;  // store loadData into the addressed slot
    logic roundGo;    // commit one halving round on this edge
  } ctrlStrobes_t;

endpackage

// File: rtl/tree_sum_ctrl.sv
module tree_sum_ctrl
  import tree_sum_pkg::*;
#(
  parameter int MAX_N = 128,
  parameter int HW    = $clog2(MAX_N + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [HW-1:0]   sumCount,
  input  logic            loadEn,
  output ctrlStrobes_t    strobes,
  output logic [HW-1:0]   curHalf,
  output logic            busy,
  output logic            done
);

  typedef enum logic {ST_IDLE, ST_RUN} ctrlState_t;

  ctrlState_t  stateQ;
  logic [HW-1:0] halfQ;
  logic          doneQ;
  logic [HW-1:0] countEff;
  logic [HW-1:0] nextHalf;

  // Counts beyond capacity are clamped to the array size.
  always_comb begin
    countEff = (sumCount > HW'(MAX_N)) ? HW'(MAX_N) : sumCount;
    nextHalf = halfQ >> 1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ <= ST_IDLE;
      halfQ  <= '0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      case (stateQ)
        ST_IDLE: begin
          if (start) begin
            if (countEff <= HW'(1)) begin
              doneQ <= 1'b1;          // nothing to fold
            end else begin
              halfQ  <= countEff;
              stateQ <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          halfQ <= nextHalf;
          if (nextHalf == HW'(1)) begin
            stateQ <= ST_IDLE;
            doneQ  <= 1'b1;
          end
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.slotWrite = (stateQ == ST_IDLE) && loadEn;
    strobes.roundGo   = (stateQ == ST_RUN);
  end

  assign curHalf = halfQ;
  assign busy    = (stateQ == ST_RUN);
  assign done    = doneQ;

endmodule

// File: rtl/tree_sum_datapath.sv
module tree_sum_datapath
  import tree_sum_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int MAX_N = 128,
  parameter int HW    = $clog2(MAX_N + 1),
  parameter int IW    = $clog2(MAX_N)
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrlStrobes_t     strobes,
  input  logic [HW-1:0]    curHalf,
  input  logic [IW-1:0]    loadIdx,
  input  logic [WIDTH-1:0] loadData,
  output logic [WIDTH-1:0] total
);

  localparam int PAIRS = MAX_N / 2;

  logic [WIDTH-1:0] slotQ   [MAX_N];
  logic [WIDTH-1:0] sumNext [PAIRS];
  logic [HW-1:0]    newHalf;
  logic [IW-1:0]    strayIdx;
  logic [WIDTH-1:0] strayVal;

  always_comb begin
    newHalf  = curHalf >> 1;
    strayIdx = IW'(curHalf - HW'(1));
    // Odd active count: the element without a partner goes to slot 0.
    strayVal = curHalf[0] ? slotQ[strayIdx] : '0;
  end

  // One adder per lower slot; every operand is a pre-round value.
  for (genvar g = 0; g < PAIRS; g++) begin : gen_pair
    logic [HW-1:0]    partnerFull;
    logic [WIDTH-1:0] partnerVal;
    always_comb begin
      partnerFull = HW'(g) + newHalf;
      partnerVal  = (HW'(g) < newHalf) ? slotQ[IW'(partnerFull)] : '0;
    end
    if (g == 0) begin : gen_head
      assign sumNext[g] = slotQ[g] + partnerVal + strayVal;
    end else begin : gen_body
      assign sumNext[g] = slotQ[g] + partnerVal;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < MAX_N; i++) slotQ[i] <= '0;
    end else if (strobes.slotWrite) begin
      slotQ[loadIdx] <= loadData;
    end else if (strobes.roundGo) begin
      for (int i = 0; i < PAIRS; i++) slotQ[i] <= sumNext[i];
    end
  end

  assign total = slotQ[0];

endmodule

// File: rtl/tree_sum_reducer.sv
module tree_sum_reducer
  import tree_sum_pkg::*;
#(
  parameter  int WIDTH = 32,
  parameter  int MAX_N = 128,
  localparam int HW    = $clog2(MAX_N + 1),
  localparam int IW    = $clog2(MAX_N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [HW-1:0]    sumCount,
  input  logic             loadEn,
  input  logic [IW-1:0]    loadIdx,
  input  logic [WIDTH-1:0] loadData,
  output logic             done,
  output logic [WIDTH-1:0] total
);

  ctrlStrobes_t  strobes;
  logic [HW-1:0] curHalf;
  logic          busy;

  tree_sum_ctrl #(.MAX_N(MAX_N), .HW(HW)) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .sumCount (sumCount),
    .loadEn   (loadEn),
    .strobes  (strobes),
    .curHalf  (curHalf),
    .busy     (busy),
    .done     (done)
  );

  tree_sum_datapath #(.WIDTH(WIDTH), .MAX_N(MAX_N), .HW(HW), .IW(IW)) dp_i (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .curHalf  (curHalf),
    .loadIdx  (loadIdx),
    .loadData (loadData),
    .total    (total)
  );

endmodule

// File: rtl/tree_sum_checker.sv
module tree_sum_checker #(
  parameter int WIDTH = 32,
  parameter int HW    = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             loadEn,
  input logic             busy,
  input logic             done,
  input logic [HW-1:0]    curHalf,
  input logic [WIDTH-1:0] total
);

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!busy && !loadEn) |=> $stable(total));

  assert_half_shrinks_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> (curHalf < $past(curHalf)));

  assert_run_count_R5: assert property (@(posedge clk) disable iff (rst)
    busy |-> (curHalf >= HW'(2)));

  assert_done_cause_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy || start));

  assert_busy_start_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && start && (curHalf > HW'(3))) |=> busy);

endmodule

bind tree_sum_reducer tree_sum_checker #(.WIDTH(WIDTH), .HW(HW)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .loadEn  (loadEn),
  .busy    (busy),
  .done    (done),
  .curHalf (curHalf),
  .total   (total)
);

// File: tb/tree_sum_reducer_tb_top.sv
`timescale 1ns/1ps
module tree_sum_reducer_tb_top;

  localparam int WIDTH = 32;
  localparam int MAX_N = 128;
  localparam int HW    = $clog2(MAX_N + 1);
  localparam int IW    = $clog2(MAX_N);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [HW-1:0]    sumCount = '0;
  logic             loadEn = 1'b0;
  logic [IW-1:0]    loadIdx = '0;
  logic [WIDTH-1:0] loadData = '0;
  logic             done;
  logic [WIDTH-1:0] total;

  always #2.5 clk = ~clk;

  tree_sum_reducer #(.WIDTH(WIDTH), .MAX_N(MAX_N)) dut_i (
    .clk(clk), .rst(rst), .start(start), .sumCount(sumCount),
    .loadEn(loadEn), .loadIdx(loadIdx), .loadData(loadData),
    .done(done), .total(total)
  );

  typedef struct {
    logic [WIDTH-1:0] sum;
    int               lat;
    string            tag;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int failures = 0;
  int cycCount = 0;
  int startCyc = 0;

  always @(posedge clk) cycCount <= cycCount + 1;

  task automatic check(input bit ok, input string tag,
                       input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [WIDTH-1:0] patVal(int pat, int i, int n);
    case (pat)
      0: return 32'd1;
      1: return 32'(i + 1);
      2: return 32'hFFFF_FFFF;
      3: return (i % 2 == 1) ? 32'(-(i * 7)) : 32'(i * 13);
      4: return (i == n - 1) ? 32'h0000_ABCD : ((i >= n) ? 32'h5555_0000 : 32'd0);
      5: return (32'(i) * 32'h9E37_79B1) ^ 32'(i << 7);
      default: return 32'h8000_0000 + 32'(i);
    endcase
  endfunction

  task automatic loadAll(input int pat, input int n);
    for (int i = 0; i < MAX_N; i++) begin
      @(negedge clk);
      loadEn   = 1'b1;
      loadIdx  = IW'(i);
      loadData = patVal(pat, i, n);
    end
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  // Driver: loads, predicts, pushes the expectation, starts, waits.
  task automatic runCase(input int n, input int pat, input string tag, input bit disturb);
    expItem_t it;
    int neff;
    int rounds;
    loadAll(pat, n);
    neff = (n > MAX_N) ? MAX_N : ((n < 1) ? 1 : n);
    it.sum = '0;
    for (int i = 0; i < neff; i++) it.sum = it.sum + patVal(pat, i, n);
    rounds = 0;
    for (int h = neff; h > 1; h = h / 2) rounds++;
    it.lat = rounds + 1;
    it.tag = tag;
    expQ.push_back(it);
    @(negedge clk);
    sumCount = HW'(n);
    start    = 1'b1;
    startCyc = cycCount;
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin
      @(negedge clk);
      start    = 1'b1;          // R8: second start while running
      loadEn   = 1'b1;          // R8: stray load into slot 0
      loadIdx  = '0;
      loadData = 32'hDEAD_BEEF;
      sumCount = HW'(2);
      @(negedge clk);
      start  = 1'b0;
      loadEn = 1'b0;
    end
    while (expQ.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // Monitor: pops on each done and compares total and latency.
  initial begin
    bit prevDone = 1'b0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (prevDone) check(!done, "R6 done width", 32'(done), 32'd0);
        if (done) begin
          if (expQ.size() == 0) begin
            check(1'b0, "R8 unexpected done", 32'(done), 32'd0);
          end else begin
            expItem_t it;
            it = expQ.pop_front();
            check(total == it.sum, {it.tag, " total"}, total, it.sum);
            check((cycCount - startCyc) == it.lat, {it.tag, " R5 latency"},
                  32'(cycCount - startCyc), 32'(it.lat));
          end
        end
        prevDone = done;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(done == 1'b0, "R1 done after reset", 32'(done), 32'd0);
    check(total == '0, "R1 total after reset", total, 32'd0);

    runCase(1,   1, "R7 R2 count one", 1'b0);
    runCase(0,   5, "R7 count zero", 1'b0);
    runCase(2,   1, "R3 count two", 1'b0);
    runCase(3,   4, "R4 odd three last slot", 1'b0);
    runCase(5,   1, "R4 count five", 1'b0);
    runCase(7,   4, "R4 odd seven last slot", 1'b0);
    runCase(100, 1, "R3 count hundred", 1'b0);
    runCase(100, 4, "R4 hundred last slot", 1'b0);
    runCase(127, 5, "R3 R4 count 127", 1'b0);
    runCase(128, 0, "R3 full ones", 1'b0);
    runCase(128, 2, "R9 wrap all ones", 1'b0);
    runCase(64,  6, "R9 wrap high bit", 1'b0);
    runCase(37,  3, "R3 signed mix", 1'b0);
    runCase(200, 1, "R10 clamp count", 1'b0);
    runCase(100, 5, "R8 busy start and load", 1'b1);

    // R2: idle with no load keeps total.
    begin
      logic [WIDTH-1:0] held;
      held = total;
      repeat (6) @(negedge clk);
      check(total == held, "R2 idle hold", total, held);
      check(done == 1'b0, "R8 no extra done", 32'(done), 32'd0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule